// File: doc/BRIEF.md
# Keyed Hashed-Index Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds 256 two-bit saturating counters, packed eight to a row in 32 rows of 16 bits. The counter that serves a branch is not picked by plain address bits. A keyed digest picks it instead. The upper half of the branch address is joined with a 16-bit history word, and the 32-bit result passes through a fixed network of XOR and rotate rounds. Eight fixed bit positions of the result are gathered and XORed with an 8-bit index key. Because the key can differ per branch or per context, two processes that share the table cannot easily predict which counter the other one uses.

The history word records the low half of the most recently resolved branch address, XORed with a 16-bit history key. It is rewritten on every update. A predict port takes an address and an index key and returns taken/not-taken one cycle later. An update port takes an address, both keys and the resolved outcome, then trains the selected counter and refreshes the history word. Both ports may fire in the same cycle.

Top module: `khbPredictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken) and the history word is 0, so every prediction made before the first update is not-taken.
- R2: `predValid` is high in exactly the cycles that follow a cycle with `predReq` high, and low in all other cycles.
- R3: When `predValid` is high, `predTaken` is 1 exactly when the counter selected by the request has the value 2 or 3.
- R4: An update with `updTaken`=1 increments the selected counter, and the counter stays at 3 once it reaches 3.
- R5: An update with `updTaken`=0 decrements the selected counter, and the counter stays at 0 once it reaches 0.
- R6: The index is formed from the word M = {addr[31:16], history}. Four rounds r=0..3 each compute M = M ^ rotl(M,5) ^ rotl(M,13) ^ rotl(32'h9E3779B9, 8r). Index bit i (i=0..7) is M[(5i+3) mod 32] XOR key bit i.
- R7: Index bits [7:3] choose the row and index bits [2:0] choose the counter slot s, which occupies row bits [2s+1:2s]. Each of the 256 index values therefore names its own counter, and training one index leaves all the others unchanged.
- R8: Each update loads the history word with `updAddr[15:0]` XOR `updHistKey`. The update's own index uses the history value from before that load.
- R9: When a prediction and an update occur in the same cycle, the prediction uses the counters and the history as they were before that update.
- R10: The low 16 bits of `predAddr` have no effect on the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| predReq | input | 1 | Prediction request strobe |
| predAddr | input | 32 | Branch address to predict |
| predIdxKey | input | 8 | Index key for the prediction |
| predValid | output | 1 | Result valid, one cycle after the request |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updReq | input | 1 | Update request strobe |
| updAddr | input | 32 | Address of the resolved branch |
| updIdxKey | input | 8 | Index key for the update |
| updHistKey | input | 16 | Key applied to the address before it enters the history |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A prediction is due exactly one clock after its request. An update changes the counters and the history at the same edge that samples it, so the next cycle's prediction already sees the change. The bench drives inputs at the falling edge and computes each expected result from its model state as it stood before the coming rising edge. At the next falling edge it compares `predValid` and `predTaken` against those expectations. The model is then updated, so simultaneous requests are checked against the pre-update state.

// File: rtl/khb_pkg.sv
package khb_pkg;

  typedef struct packed {
    logic predFire;
    logic updFire;
  } khbStrobe_t;

endpackage

// File: rtl/khbMixer.sv
module khbMixer #(
  parameter int W = 32,
  parameter int ROUNDS = 4,
  parameter int IDX_W = 8,
  parameter int ROT_A = 5,
  parameter int ROT_B = 13,
  parameter int RC_STEP = 8,
  parameter int SEL_STEP = 5,
  parameter int SEL_OFS = 3,
  parameter logic [W-1:0] RC_BASE = 32'h9E3779B9
) (
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] key,
  output logic [IDX_W-1:0] idx
);

  logic [W-1:0] stage [ROUNDS+1];

  assign stage[0] = din;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    localparam int K = (RC_STEP * r) % W;
    localparam logic [W-1:0] RC = (RC_BASE << K) | (RC_BASE >> (W - K));
    logic [W-1:0] rotA;
    logic [W-1:0] rotB;
    assign rotA = (stage[r] << ROT_A) | (stage[r] >> (W - ROT_A));
    assign rotB = (stage[r] << ROT_B) | (stage[r] >> (W - ROT_B));
    assign stage[r+1] = stage[r] ^ rotA ^ rotB ^ RC;
  end

  for (genvar i = 0; i < IDX_W; i++) begin : g_sel
    assign idx[i] = stage[ROUNDS][(SEL_STEP * i + SEL_OFS) % W] ^ key[i];
  end

endmodule

// File: rtl/khbCtrl.sv
module khbCtrl
  import khb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       predReq,
  input  logic       updReq,
  output khbStrobe_t strobe,
  output logic       predValid
);

  always_comb begin
    strobe.predFire = predReq;
    strobe.updFire  = updReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= predReq;
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    predReq |=> predValid);  // R2
  AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !predReq |=> !predValid);  // R2

endmodule

// File: rtl/khbDatapath.sv
module khbDatapath
  import khb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 16,
  parameter int IDX_W = 8,
  parameter int CNT_PER_ROW = 8,
  parameter int MIX_ROUNDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  khbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] predAddr,
  input  logic [IDX_W-1:0]  predIdxKey,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [IDX_W-1:0]  updIdxKey,
  input  logic [HIST_W-1:0] updHistKey,
  input  logic              updTaken,
  output logic              predTaken
);

  localparam int SLOT_W   = $clog2(CNT_PER_ROW);
  localparam int ROW_W    = IDX_W - SLOT_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int ROW_BITS = 2 * CNT_PER_ROW;
  localparam int MIX_W    = 2 * HIST_W;

  logic [ROW_BITS-1:0] tblQ [ROWS];
  logic [HIST_W-1:0]   histQ;

  logic [IDX_W-1:0] predIdx;
  logic [IDX_W-1:0] updIdx;
  logic [1:0]       predCnt;
  logic [1:0]       updOld;
  logic [1:0]       updNew;

  khbMixer #(.W(MIX_W), .ROUNDS(MIX_ROUNDS), .IDX_W(IDX_W)) u_predMix (
    .din ({predAddr[ADDR_W-1 -: HIST_W], histQ}),
    .key (predIdxKey),
    .idx (predIdx)
  );

  khbMixer #(.W(MIX_W), .ROUNDS(MIX_ROUNDS), .IDX_W(IDX_W)) u_updMix (
    .din ({updAddr[ADDR_W-1 -: HIST_W], histQ}),
    .key (updIdxKey),
    .idx (updIdx)
  );

  function automatic logic [1:0] cntAt(input logic [IDX_W-1:0] i);
    logic [ROW_BITS-1:0] row;
    row = tblQ[i[IDX_W-1:SLOT_W]];
    return row[i[SLOT_W-1:0]*2 +: 2];
  endfunction

  always_comb begin
    predCnt = cntAt(predIdx);
    updOld  = cntAt(updIdx);
    if (updTaken) updNew = (updOld == 2'd3) ? 2'd3 : updOld + 2'd1;
    else          updNew = (updOld == 2'd0) ? 2'd0 : updOld - 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) tblQ[r] <= {CNT_PER_ROW{2'b01}};
      histQ     <= '0;
      predTaken <= 1'b0;
    end else begin
      if (strobe.updFire) begin
        tblQ[updIdx[IDX_W-1:SLOT_W]][updIdx[SLOT_W-1:0]*2 +: 2] <= updNew;
        histQ <= updAddr[HIST_W-1:0] ^ updHistKey;
      end
      if (strobe.predFire) predTaken <= predCnt[1];
    end
  end

  AST_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updFire && updTaken |=>
      (cntAt($past(updIdx)) == (($past(updOld) == 2'd3) ? 2'd3 : $past(updOld) + 2'd1)));  // R4
  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updFire && !updTaken |=>
      (cntAt($past(updIdx)) == (($past(updOld) == 2'd0) ? 2'd0 : $past(updOld) - 2'd1)));  // R5
  AST_HIST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updFire |=> (histQ == ($past(updAddr[HIST_W-1:0]) ^ $past(updHistKey))));  // R8
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.updFire |=> $stable(histQ));  // R8

endmodule

// File: rtl/khbPredictor.sv
module khbPredictor
  import khb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 16,
  parameter int IDX_W = 8,
  parameter int CNT_PER_ROW = 8,
  parameter int MIX_ROUNDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predReq,
  input  logic [ADDR_W-1:0] predAddr,
  input  logic [IDX_W-1:0]  predIdxKey,
  output logic              predValid,
  output logic              predTaken,
  input  logic              updReq,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [IDX_W-1:0]  updIdxKey,
  input  logic [HIST_W-1:0] updHistKey,
  input  logic              updTaken
);

  khbStrobe_t strobe;

  khbCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .predReq   (predReq),
    .updReq    (updReq),
    .strobe    (strobe),
    .predValid (predValid)
  );

  khbDatapath #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W),
    .CNT_PER_ROW(CNT_PER_ROW), .MIX_ROUNDS(MIX_ROUNDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .predAddr   (predAddr),
    .predIdxKey (predIdxKey),
    .updAddr    (updAddr),
    .updIdxKey  (updIdxKey),
    .updHistKey (updHistKey),
    .updTaken   (updTaken),
    .predTaken  (predTaken)
  );

endmodule

// File: tb/khbPredictor_bench.sv
`timescale 1ns/1ps
module khbPredictor_bench;

  localparam real CLK_HALF = 2.5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        predReq = 1'b0;
  logic [31:0] predAddr = '0;
  logic [7:0]  predIdxKey = '0;
  logic        predValid;
  logic        predTaken;
  logic        updReq = 1'b0;
  logic [31:0] updAddr = '0;
  logic [7:0]  updIdxKey = '0;
  logic [15:0] updHistKey = '0;
  logic        updTaken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int          cnt [256];
  logic [15:0] hist;
  bit          expValid = 0;
  bit          expTaken = 0;
  string       expTag = "R2";

  always #(CLK_HALF) clk = ~clk;

  khbPredictor u_khbPredictor (
    .clk(clk), .rstN(rstN),
    .predReq(predReq), .predAddr(predAddr), .predIdxKey(predIdxKey),
    .predValid(predValid), .predTaken(predTaken),
    .updReq(updReq), .updAddr(updAddr), .updIdxKey(updIdxKey),
    .updHistKey(updHistKey), .updTaken(updTaken)
  );

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    if (n == 0) return x;
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic int modelIdx(input logic [31:0] a, input logic [7:0] k);
    logic [31:0] m;
    logic [7:0] ix;
    m = {a[31:16], hist};
    for (int r = 0; r < 4; r++)
      m = m ^ rotl(m, 5) ^ rotl(m, 13) ^ rotl(32'h9E3779B9, (8 * r) % 32);
    for (int i = 0; i < 8; i++) ix[i] = m[(5 * i + 3) % 32] ^ k[i];
    return int'(ix);
  endfunction

  task automatic checkOut();
    checks++;
    if (predValid !== expValid) begin
      failures++;
      $display("FAIL R2 predValid actual=%0b expected=%0b", predValid, expValid);
    end
    if (expValid) begin
      checks++;
      if (predTaken !== expTaken) begin
        failures++;
        $display("FAIL %s predTaken actual=%0b expected=%0b", expTag, predTaken, expTaken);
      end
    end
  endtask

  task automatic step(input bit pr, input logic [31:0] pa, input logic [7:0] pk,
                      input bit ur, input logic [31:0] ua, input logic [7:0] uk,
                      input logic [15:0] uh, input bit ut, input string tag);
    int i;
    @(negedge clk);
    checkOut();
    predReq = pr; predAddr = pa; predIdxKey = pk;
    updReq = ur; updAddr = ua; updIdxKey = uk; updHistKey = uh; updTaken = ut;
    expValid = pr;
    expTag = tag;
    if (pr) expTaken = (cnt[modelIdx(pa, pk)] >= 2);
    if (ur) begin
      i = modelIdx(ua, uk);
      if (ut) cnt[i] = (cnt[i] == 3) ? 3 : cnt[i] + 1;
      else    cnt[i] = (cnt[i] == 0) ? 0 : cnt[i] - 1;
      hist = ua[15:0] ^ uh;
    end
  endtask

  task automatic pred(input logic [31:0] a, input logic [7:0] k, input string tag);
    step(1, a, k, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic upd(input logic [31:0] a, input logic [7:0] k, input logic [15:0] h,
                     input bit t, input string tag);
    step(0, '0, '0, 1, a, k, h, t, tag);
  endtask

  task automatic idle(input string tag);
    step(0, '0, '0, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] pool [4];
    pool[0] = 32'h1234_5678; pool[1] = 32'hABCD_0001;
    pool[2] = 32'h0F0F_8000; pool[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 256; i++) cnt[i] = 1;
    hist = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (predValid !== 1'b0 || predTaken !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%0b%0b expected=00", predValid, predTaken);
    end
    rstN = 1'b1;

    // R1: fresh table predicts not-taken everywhere
    pred(pool[0], 8'h00, "R1");
    pred(pool[1], 8'h3C, "R1");
    pred(pool[2], 8'hFF, "R1");
    idle("R2");
    idle("R2");

    // R4: train taken past saturation
    for (int n = 0; n < 5; n++) upd(pool[0], 8'h00, 16'h0000, 1, "R4");
    pred(pool[0], 8'h00, "R4");
    // R5: train not-taken past saturation
    for (int n = 0; n < 5; n++) upd(pool[0], 8'h00, 16'h0000, 0, "R5");
    pred(pool[0], 8'h00, "R5");
    upd(pool[0], 8'h00, 16'h0000, 1, "R5");
    pred(pool[0], 8'h00, "R5");

    // R6: index depends on key and digest
    for (int n = 0; n < 3; n++) upd(pool[1], 8'h5A, 16'h00FF, 1, "R6");
    pred(pool[1], 8'h5A, "R6");
    pred(pool[1], 8'h00, "R6");
    pred(pool[1], 8'hA5, "R6");

    // R7: training one index does not disturb others
    for (int k = 0; k < 8; k++) pred(pool[2], 8'(1 << k), "R7");
    for (int n = 0; n < 3; n++) upd(pool[2], 8'h01, 16'h8000, 1, "R7");
    for (int k = 0; k < 8; k++) pred(pool[2], 8'(1 << k), "R7");

    // R8: history word changes the index
    upd(pool[3], 8'h11, 16'h1234, 1, "R8");
    pred(pool[1], 8'h5A, "R8");
    upd(pool[3], 8'h11, 16'hFFFF, 1, "R8");
    pred(pool[1], 8'h5A, "R8");
    upd(pool[1], 8'h5A, 16'h00FF, 1, "R8");
    pred(pool[1], 8'h5A, "R8");

    // R9: simultaneous predict and update
    for (int n = 0; n < 4; n++)
      step(1, pool[0], 8'h22, 1, pool[0], 8'h22, 16'h0000, 1, "R9");
    for (int n = 0; n < 4; n++)
      step(1, pool[0], 8'h22, 1, pool[0], 8'h22, 16'h0000, 0, "R9");

    // R10: low address half is irrelevant
    for (int n = 0; n < 3; n++) upd(pool[1], 8'h07, 16'h0001, 1, "R10");
    pred(pool[1], 8'h07, "R10");
    pred({pool[1][31:16], 16'hBEEF}, 8'h07, "R10");
    pred({pool[1][31:16], 16'h0000}, 8'h07, "R10");

    // R3: mixed traffic with a small address and key pool
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pa, ua;
      logic [7:0] pk, uk;
      pa = pool[$urandom_range(0, 3)] ^ {16'h0, 16'($urandom)};
      ua = pool[$urandom_range(0, 3)] ^ {16'h0, 16'($urandom)};
      pk = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'h5A;
      uk = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'h5A;
      step($urandom_range(0, 3) != 0, pa, pk, $urandom_range(0, 1) == 1, ua, uk,
           16'($urandom_range(0, 3)), $urandom_range(0, 2) != 0, "R3");
    end
    idle("R2");
    idle("R2");
    summary();
  end

endmodule